// File: doc/BRIEF.md
# Byte-Lane Static Memory with Two Chip Selects

This block is a clocked, synthesizable model of a 16-bit-wide static memory. It keeps the control pins of an asynchronous memory device: one select that is active low, one that is active high, a write strobe, an output-enable strobe and one select per byte. All of them are sampled on the rising clock edge. The bidirectional data pins are split into a write-data bus, a read-data bus and one output-enable bit per byte lane. A testbench or pad wrapper uses those bits to model lanes that float.

On every edge a decoder sorts the sampled controls into one of four operations. The operation is stored in a state register, so the state always shows what the previous edge did. The states are `ST_STANDBY`, `ST_READ`, `ST_WRITE` and `ST_OUTOFF`. Every state can move to every other state on any edge, and the next state is the decoded operation. The transitions are named by their target: *deselect* or *no-lane* goes to `ST_STANDBY`, *write* goes to `ST_WRITE`, *read* goes to `ST_READ`, and *output-off* goes to `ST_OUTOFF`. The storage is two byte-wide banks, built by a generate loop. Each bank has its own write enable and its own read enable, so it maps onto block RAM with byte writes.

The address port is 18 bits wide. Only the low `$clog2(DEPTH)` bits select a word, and `DEPTH` defaults to 1024.

Top module: `lane_sram`

## Requirements
- R1: Lane 0 is data bits 7:0 and is gated by `lo_n`. Lane 1 is data bits 15:8 and is gated by `hi_n`. `rdata_oe[0]` belongs to lane 0 and `rdata_oe[1]` to lane 1.
- R2: The part counts as selected only when `sel_n` is 0 and `sel_p` is 1 at the edge. In any other case no word is written, and both bits of `rdata_oe` are 0 after that edge.
- R3: If `hi_n` and `lo_n` are both 1 at the edge, no write takes place and both lanes float after the edge, whatever the other controls are.
- R4: A read needs the part selected with `wr_n`=1 and `oe_n`=0. After the edge, each lane whose byte select was 0 drives the stored byte of the addressed word, with its `rdata_oe` bit at 1. Each lane whose byte select was 1 floats.
- R5: A write needs the part selected with `wr_n`=0. At the edge, each lane whose byte select is 0 stores its byte of `wdata`, and the other lane keeps its old contents. Both lanes float after the edge, and `oe_n` has no effect.
- R6: If the part is selected with `wr_n`=1 and `oe_n`=1, both lanes float after the edge and the memory is left unchanged.
- R7: Address bits at and above `$clog2(DEPTH)` are ignored. Two addresses that differ only in those bits reach the same word.
- R8: While `rst_n` is 0, `rdata_oe` is 0 and `rdata` is 0.
- R9: A lane whose `rdata_oe` bit is 0 shows zero on its byte of `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| sel_p | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| hi_n | input | 1 | Upper byte (15:8) select, active low |
| lo_n | input | 1 | Lower byte (7:0) select, active low |
| addr | input | 18 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero on lanes that float |
| rdata_oe | output | 2 | Per-lane drive enable (bit 0 = lower byte) |

## Verification
The bench builds the block with `DEPTH`=64, so only six address bits are decoded. This lets a few thousand random operations revisit every word many times. It also lets random addresses with nonzero upper bits test the aliasing rule of R7 against a reference array of the same size. The small depth also makes a complete preload of the array cheap, so every random read has a known expected word.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_READ    = 2'd1,
        ST_WRITE   = 2'd2,
        ST_OUTOFF  = 2'd3
    } lane_state_e;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;

endpackage

// File: rtl/lane_sram_decode.sv
module lane_sram_decode
    import lane_sram_pkg::*;
(
    input  logic              sel_n,
    input  logic              sel_p,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic [LANES-1:0]  lane_n,
    output lane_state_e       next_st,
    output logic [LANES-1:0]  lane_we,
    output logic [LANES-1:0]  lane_re
);

    logic             picked;
    logic [LANES-1:0] lane_on;

    assign picked  = !sel_n && sel_p;
    assign lane_on = ~lane_n;

    always_comb begin
        next_st = ST_STANDBY;
        lane_we = '0;
        lane_re = '0;
        if (!picked || lane_on == '0) begin
            next_st = ST_STANDBY;
        end else if (!wr_n) begin
            next_st = ST_WRITE;
            lane_we = lane_on;
        end else if (!oe_n) begin
            next_st = ST_READ;
            lane_re = lane_on;
        end else begin
            next_st = ST_OUTOFF;
        end
    end

endmodule

// File: rtl/lane_sram_bank.sv
module lane_sram_bank #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] rd
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[idx] <= wd;
        end
        if (re) begin
            rd <= cells[idx];
        end
    end

endmodule

// File: rtl/lane_sram.sv
module lane_sram
    import lane_sram_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = 18,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel_p,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic              hi_n,
    input  logic              lo_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [LANES-1:0]  rdata_oe
);

    lane_state_e      state_q;
    lane_state_e      next_st;
    logic [LANES-1:0] lane_we;
    logic [LANES-1:0] lane_re;
    logic [LANES-1:0] lanes_q;
    logic [IDX_W-1:0] idx;
    logic [WORD_W-1:0] bank_rd;

    // R1: lane 0 follows lo_n, lane 1 follows hi_n
    lane_sram_decode u_decode (
        .sel_n   (sel_n),
        .sel_p   (sel_p),
        .wr_n    (wr_n),
        .oe_n    (oe_n),
        .lane_n  ({hi_n, lo_n}),
        .next_st (next_st),
        .lane_we (lane_we),
        .lane_re (lane_re)
    );

    // R7: word index taken from the low address bits only
    assign idx = addr[IDX_W-1:0];

    generate
        if (IDX_W < ADDR_W) begin : g_hi_bits
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_W-1:IDX_W];
        end
    endgenerate

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            lane_sram_bank #(
                .DEPTH  (DEPTH),
                .DATA_W (LANE_W)
            ) u_bank (
                .clk (clk),
                .we  (lane_we[g]),
                .re  (lane_re[g]),
                .idx (idx),
                .wd  (wdata[g*LANE_W +: LANE_W]),
                .rd  (bank_rd[g*LANE_W +: LANE_W])
            );
        end
    endgenerate

    // State register: records the operation decoded at the last edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
            lanes_q <= '0;
        end else begin
            state_q <= next_st;
            lanes_q <= lane_re;
        end
    end

    // Outputs: lanes drive only in the read state
    always_comb begin
        rdata_oe = '0;
        rdata    = '0;
        unique case (state_q)
            ST_READ: begin
                rdata_oe = lanes_q;
                for (int i = 0; i < LANES; i++) begin
                    if (lanes_q[i]) begin
                        rdata[i*LANE_W +: LANE_W] = bank_rd[i*LANE_W +: LANE_W];
                    end
                end
            end
            ST_STANDBY, ST_WRITE, ST_OUTOFF: begin
                rdata_oe = '0;
                rdata    = '0;
            end
            default: begin
                rdata_oe = '0;
                rdata    = '0;
            end
        endcase
    end

    AST_DESELECT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || !sel_p) |=> (rdata_oe == '0)); // R2

    AST_NOLANE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_n && lo_n) |=> (rdata_oe == '0)); // R3

    AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && sel_p && wr_n && !oe_n) |=> (rdata_oe == ~$past({hi_n, lo_n}))); // R4

    AST_WRITE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && sel_p && !wr_n) |=> (rdata_oe == '0)); // R5

    AST_OUTOFF_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && sel_p && wr_n && oe_n) |=> (rdata_oe == '0)); // R6

    AST_WRITE_READ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_we & lane_re) == '0)); // R5

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (rdata_oe == '0); // R8
        end
    end

endmodule

// File: tb/lane_sram_test.sv
module lane_sram_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int ADDR_W     = 18;
    localparam int RAND_OPS   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        sel_p = 1'b0;
    logic        wr_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        hi_n = 1'b1;
    logic        lo_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  rdata_oe;

    logic [15:0] model [DEPTH];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_sram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .sel_p    (sel_p),
        .wr_n     (wr_n),
        .oe_n     (oe_n),
        .hi_n     (hi_n),
        .lo_n     (lo_n),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

    function automatic string op_tag(logic sn, logic sp, logic wn, logic on, logic hn, logic ln);
        if (sn || !sp) return "R2";
        if (hn && ln) return "R3";
        if (!wn) return "R5";
        if (!on) return "R4";
        return "R6";
    endfunction

    function automatic logic [1:0] exp_oe(logic sn, logic sp, logic wn, logic on, logic hn, logic ln);
        if (sn || !sp || (hn && ln) || !wn || on) return 2'b00;
        return ~{hn, ln};
    endfunction

    task automatic check(string tag, logic [1:0] eoe, logic [15:0] erd);
        checks++;
        if (rdata_oe !== eoe || rdata !== erd) begin
            fails++;
            $display("FAIL %s: rdata_oe=%b rdata=%h expected rdata_oe=%b rdata=%h",
                     tag, rdata_oe, rdata, eoe, erd);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge after checking
    task automatic apply(string tag_in, logic sn, logic sp, logic wn, logic on,
                         logic hn, logic ln, logic [ADDR_W-1:0] a, logic [15:0] d);
        logic [1:0]  eoe;
        logic [15:0] erd;
        int          w;
        string       tag;
        sel_n = sn; sel_p = sp; wr_n = wn; oe_n = on;
        hi_n = hn; lo_n = ln; addr = a; wdata = d;
        w = int'(a % DEPTH);
        tag = (tag_in.len() > 0) ? tag_in : op_tag(sn, sp, wn, on, hn, ln);
        @(posedge clk);
        if (!sn && sp && !wn) begin
            if (!ln) model[w][7:0]  = d[7:0];
            if (!hn) model[w][15:8] = d[15:8];
        end
        eoe = exp_oe(sn, sp, wn, on, hn, ln);
        erd = 16'h0000;
        if (eoe[0]) erd[7:0]  = model[w][7:0];
        if (eoe[1]) erd[15:8] = model[w][15:8];
        @(negedge clk);
        check(tag, eoe, erd);
    endtask

    task automatic rd_full(string tag, logic [ADDR_W-1:0] a);
        apply(tag, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, a, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) model[i] = 16'h0;
        repeat (3) @(negedge clk);
        check("R8", 2'b00, 16'h0000);          // R8 reset state
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", 2'b00, 16'h0000);

        // Preload every word with a full write (R5)
        for (int i = 0; i < DEPTH; i++) begin
            apply("R5", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, ADDR_W'(i), 16'(i * 16'h0101 + 16'h1357));
        end

        // R1 + R5: lower-only write leaves upper byte, oe_n low ignored
        apply("R5", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 18'd5, 16'hAAC3);
        rd_full("R1", 18'd5);
        // R1 + R5: upper-only write
        apply("R5", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 18'd6, 16'h5Bff);
        rd_full("R1", 18'd6);
        // R4: single-lane reads
        apply("R4", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 18'd6, 16'h0);
        apply("R4", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 18'd5, 16'h0);
        // R2: write with either select inactive changes nothing
        apply("R2", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 18'd7, 16'hDEAD);
        apply("R2", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 18'd7, 16'hBEEF);
        apply("R2", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 18'd7, 16'h0);
        rd_full("R2", 18'd7);
        // R3: no byte selected, write and read attempts float
        apply("R3", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 18'd8, 16'hF00D);
        apply("R3", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 18'd8, 16'h0);
        rd_full("R3", 18'd8);
        // R6: output off
        apply("R6", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 18'd9, 16'h0);
        rd_full("R6", 18'd9);
        // R7: aliased address writes the same word
        apply("R7", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 18'h3FFCA, 16'h7E81);
        rd_full("R7", 18'd10);
        rd_full("R7", 18'h2004A);
        // R9: idle lane shows zero on a single-lane read
        apply("R9", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 18'd10, 16'h0);

        for (int n = 0; n < RAND_OPS; n++) begin
            logic sn, sp, wn, on, hn, ln;
            sn = ($urandom % 8) == 0;
            sp = ($urandom % 8) != 0;
            wn = ($urandom % 3) != 0;
            on = ($urandom % 5) == 0;
            hn = ($urandom % 3) == 0;
            ln = ($urandom % 3) == 0;
            apply("", sn, sp, wn, on, hn, ln, ADDR_W'($urandom), 16'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule